// File: doc/BRIEF.md
# Floating-Point Register Load/Store Sequencer

This block carries floating-point load and store instructions between a 32-entry by 32-bit floating-point register file that it holds and a word-wide memory port. Each instruction arrives with the two integer register values it names. The block decodes the instruction, forms the effective address, and then either moves one word or moves an aligned pair of words to or from an even/odd register pair. A doubleword request with a bad address or a bad register number is not sent to memory. It ends in a one-cycle trap pulse that carries a cause code.

The instruction input is a valid/ready stream. `ins_ready` is high only while the block is idle, so an instruction is taken on any rising edge where both `ins_valid` and `ins_ready` are high. The memory side is a request/ready handshake. `mem_req` stays high with address, direction and write data held until the edge on which `mem_rdy` is also high. For a read, `mem_rdata` must be valid in that same cycle. Memory can therefore stall each word for any number of cycles.

Instruction encoding: bits 31:30 must be `11`. Bits 24:19 select the operation: `0x20` word load, `0x23` doubleword load, `0x24` word store, `0x27` doubleword store. Bits 29:25 give the FP register number. Bit 13 selects immediate addressing, and bits 12:0 hold the immediate. Bits 18:14 are not used, because the integer operands arrive as values.

Top module: `fpmem_xfer_unit`

## Requirements
- R1: With bit 13 clear, the effective address is `rs1_val + rs2_val`, modulo 2^32.
- R2: With bit 13 set, the effective address is `rs1_val` plus bits 12:0 sign-extended from bit 12.
- R3: A word load (op `0x20`) issues exactly one request with `mem_we`=0 at the effective address, and writes `mem_rdata` into register rd.
- R4: A word store (op `0x24`) issues exactly one request with `mem_we`=1 and `mem_wdata` equal to register rd. Any address is issued unchanged, including one whose low two bits are not zero.
- R5: A doubleword load (op `0x23`, rd even, address aligned to 8) issues two read requests, at ea and then at ea+4. It writes the first word into rd and the second into rd+1.
- R6: A doubleword store (op `0x27`, rd even, address aligned to 8) writes rd to ea and then rd+1 to ea+4, in that order.
- R7: A doubleword access whose effective address has any of bits 2:0 set makes no memory request, changes no register, and traps with cause `01`. This cause wins over an odd register number.
- R8: An aligned doubleword access with an odd rd makes no memory request, changes no register, and traps with cause `10`.
- R9: An instruction whose bits 31:30 are not `11`, or whose op field is none of the four codes, makes no request, changes no register, and traps with cause `10`.
- R10: After an instruction is accepted, the next cycle shows either a memory request or `trap_valid`. A trap lasts exactly one cycle, and `ins_ready` is high in the following cycle.
- R11: While `mem_req` is high and `mem_rdy` is low, `mem_addr`, `mem_we` and `mem_wdata` hold their values. The second word of a pair is not requested before the first has completed.
- R12: After reset `ins_ready` is 1 and `mem_req` and `trap_valid` are 0. `ins_ready` stays low from acceptance until the instruction has finished.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ins_valid | input | 1 | Instruction and operands are valid |
| ins_ready | output | 1 | Block is idle and takes an instruction |
| ins_word | input | 32 | Instruction word |
| rs1_val | input | 32 | First integer operand value |
| rs2_val | input | 32 | Second integer operand value (register-register mode) |
| mem_req | output | 1 | Memory word request |
| mem_rdy | input | 1 | Memory completes the request this cycle |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | 32 | Byte address of the word |
| mem_wdata | output | 32 | Store data |
| mem_rdata | input | 32 | Load data, valid with `mem_rdy` |
| trap_valid | output | 1 | One-cycle trap pulse |
| trap_cause | output | 2 | `01` misaligned, `10` illegal instruction |

## Verification
A wrong sequencer state shows at the ports within one cycle of acceptance. It appears as a request where a trap was due, a trap pulse longer than one cycle, or a `mem_req` that drops while memory is still stalling. A wrong second-beat register or address shows on the next handshake as a bad `mem_addr` or store data. A wrong load target is hidden until a later store reads that register back. For that reason the stimulus reads the whole register file back through stores after every error sweep.

// File: rtl/fpls_pkg.sv
package fpls_pkg;

  typedef enum logic [1:0] {
    CAUSE_NONE     = 2'b00,
    CAUSE_MISALIGN = 2'b01,
    CAUSE_ILLEGAL  = 2'b10
  } trap_cause_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'b00,
    ST_TRAP  = 2'b01,
    ST_WORD0 = 2'b10,
    ST_WORD1 = 2'b11
  } seq_state_e;

  localparam logic [1:0] MAJOR_MEM = 2'b11;
  localparam logic [5:0] OP3_LDW   = 6'h20;
  localparam logic [5:0] OP3_LDD   = 6'h23;
  localparam logic [5:0] OP3_STW   = 6'h24;
  localparam logic [5:0] OP3_STD   = 6'h27;

  typedef struct packed {
    logic is_store;
    logic is_dbl;
  } xfer_attr_t;

endpackage

// File: rtl/fpls_decode.sv
module fpls_decode
  import fpls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5,
  parameter int IMM_W  = 13
) (
  input  logic [31:0]       ins_word,
  input  logic [ADDR_W-1:0] rs1_val,
  input  logic [ADDR_W-1:0] rs2_val,
  output logic [ADDR_W-1:0] ea,
  output logic [RIDX_W-1:0] rd,
  output xfer_attr_t        attr,
  output trap_cause_e       cause
);

  localparam int IMM_SEL_BIT = IMM_W;
  localparam int EXT_W       = ADDR_W - IMM_W;
  localparam int ALIGN_BITS  = 3;

  logic [5:0]        op3;
  logic [IMM_W-1:0]  imm;
  logic [ADDR_W-1:0] offset;
  logic              known;
  logic              misaligned;
  logic              odd_pair;
  logic              unused_int_field;

  assign op3 = ins_word[24:19];
  assign imm = ins_word[IMM_W-1:0];
  assign rd  = ins_word[25 +: RIDX_W];
  assign unused_int_field = ^ins_word[18:14];

  assign offset = ins_word[IMM_SEL_BIT] ? {{EXT_W{imm[IMM_W-1]}}, imm} : rs2_val;
  assign ea     = rs1_val + offset;

  always_comb begin
    known         = 1'b1;
    attr.is_store = 1'b0;
    attr.is_dbl   = 1'b0;
    if (ins_word[31:30] != MAJOR_MEM) begin
      known = 1'b0;
    end else begin
      case (op3)
        OP3_LDW: begin attr.is_store = 1'b0; attr.is_dbl = 1'b0; end
        OP3_LDD: begin attr.is_store = 1'b0; attr.is_dbl = 1'b1; end
        OP3_STW: begin attr.is_store = 1'b1; attr.is_dbl = 1'b0; end
        OP3_STD: begin attr.is_store = 1'b1; attr.is_dbl = 1'b1; end
        default: known = 1'b0;
      endcase
    end
  end

  assign misaligned = attr.is_dbl && (|ea[ALIGN_BITS-1:0]);
  assign odd_pair   = attr.is_dbl && rd[0];

  always_comb begin
    if (!known)          cause = CAUSE_ILLEGAL;
    else if (misaligned) cause = CAUSE_MISALIGN;
    else if (odd_pair)   cause = CAUSE_ILLEGAL;
    else                 cause = CAUSE_NONE;
  end

endmodule

// File: rtl/fpls_regfile.sv
module fpls_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data
);

  logic [DATA_W-1:0] entry [REG_CNT];

  for (genvar g = 0; g < REG_CNT; g++) begin : g_entry
    logic hit;
    assign hit = wr_en && (wr_idx == IDX_W'(g));
    always_ff @(posedge clk) begin
      if (!rst_n)   entry[g] <= '0;
      else if (hit) entry[g] <= wr_data;
    end
  end

  assign rd_data = entry[rd_idx];

endmodule

// File: rtl/fpls_seq.sv
module fpls_seq
  import fpls_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [ADDR_W-1:0] dec_ea,
  input  logic [RIDX_W-1:0] dec_rd,
  input  xfer_attr_t        dec_attr,
  input  trap_cause_e       dec_cause,
  output logic              mem_req,
  input  logic              mem_rdy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [RIDX_W-1:0] reg_idx,
  output logic              rf_we,
  output logic              trap_valid,
  output trap_cause_e       trap_cause
);

  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(4);

  seq_state_e        state;
  logic [ADDR_W-1:0] ea_q;
  logic [RIDX_W-1:0] rd_q;
  xfer_attr_t        attr_q;
  trap_cause_e       cause_q;
  logic              beat_done;

  assign ins_ready  = (state == ST_IDLE);
  assign mem_req    = (state == ST_WORD0) || (state == ST_WORD1);
  assign beat_done  = mem_req && mem_rdy;
  assign mem_we     = attr_q.is_store;
  assign mem_addr   = (state == ST_WORD1) ? ea_q + WORD_STEP : ea_q;
  assign reg_idx    = (state == ST_WORD1) ? {rd_q[RIDX_W-1:1], 1'b1} : rd_q;
  assign rf_we      = beat_done && !attr_q.is_store;
  assign trap_valid = (state == ST_TRAP);
  assign trap_cause = trap_valid ? cause_q : CAUSE_NONE;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      ea_q    <= '0;
      rd_q    <= '0;
      attr_q  <= '0;
      cause_q <= CAUSE_NONE;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ins_valid) begin
            ea_q    <= dec_ea;
            rd_q    <= dec_rd;
            attr_q  <= dec_attr;
            cause_q <= dec_cause;
            state   <= (dec_cause != CAUSE_NONE) ? ST_TRAP : ST_WORD0;
          end
        end
        ST_TRAP: state <= ST_IDLE;
        ST_WORD0: begin
          if (mem_rdy) state <= attr_q.is_dbl ? ST_WORD1 : ST_IDLE;
        end
        ST_WORD1: begin
          if (mem_rdy) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fpmem_xfer_unit.sv
module fpmem_xfer_unit
  import fpls_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  parameter int IMM_W   = 13,
  localparam int RIDX_W = $clog2(REG_CNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ins_valid,
  output logic              ins_ready,
  input  logic [31:0]       ins_word,
  input  logic [ADDR_W-1:0] rs1_val,
  input  logic [ADDR_W-1:0] rs2_val,
  output logic              mem_req,
  input  logic              mem_rdy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              trap_valid,
  output logic [1:0]        trap_cause
);

  logic [ADDR_W-1:0] dec_ea;
  logic [RIDX_W-1:0] dec_rd;
  xfer_attr_t        dec_attr;
  trap_cause_e       dec_cause;
  logic [RIDX_W-1:0] reg_idx;
  logic              rf_we;
  logic [DATA_W-1:0] rf_rdata;
  trap_cause_e       cause_out;

  fpls_decode #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W), .IMM_W(IMM_W)) u_decode (
    .ins_word (ins_word),
    .rs1_val  (rs1_val),
    .rs2_val  (rs2_val),
    .ea       (dec_ea),
    .rd       (dec_rd),
    .attr     (dec_attr),
    .cause    (dec_cause)
  );

  fpls_seq #(.ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ins_valid  (ins_valid),
    .ins_ready  (ins_ready),
    .dec_ea     (dec_ea),
    .dec_rd     (dec_rd),
    .dec_attr   (dec_attr),
    .dec_cause  (dec_cause),
    .mem_req    (mem_req),
    .mem_rdy    (mem_rdy),
    .mem_we     (mem_we),
    .mem_addr   (mem_addr),
    .reg_idx    (reg_idx),
    .rf_we      (rf_we),
    .trap_valid (trap_valid),
    .trap_cause (cause_out)
  );

  fpls_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (rf_we),
    .wr_idx  (reg_idx),
    .wr_data (mem_rdata),
    .rd_idx  (reg_idx),
    .rd_data (rf_rdata)
  );

  assign mem_wdata  = rf_rdata;
  assign trap_cause = cause_out;

endmodule

// File: rtl/fpls_checker.sv
module fpls_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              ins_valid,
  input logic              ins_ready,
  input logic              mem_req,
  input logic              mem_rdy,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              trap_valid,
  input logic [1:0]        trap_cause
);

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rdy) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata))); // R11

  AST_PAIR_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && mem_rdy) && mem_req) |-> (mem_addr == $past(mem_addr) + ADDR_W'(4))); // R5

  AST_PAIR_DIR: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mem_req && mem_rdy) && mem_req) |-> (mem_we == $past(mem_we))); // R6

  AST_TRAP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> (!trap_valid && ins_ready)); // R10

  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (!mem_req && !ins_ready)); // R7

  AST_CAUSE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> (trap_cause == 2'b01 || trap_cause == 2'b10)); // R8

  AST_START_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && ins_ready) |=> (mem_req ^ trap_valid)); // R10

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    ins_ready |-> (!mem_req && !trap_valid)); // R12

endmodule

bind fpmem_xfer_unit fpls_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .ins_valid  (ins_valid),
  .ins_ready  (ins_ready),
  .mem_req    (mem_req),
  .mem_rdy    (mem_rdy),
  .mem_we     (mem_we),
  .mem_addr   (mem_addr),
  .mem_wdata  (mem_wdata),
  .trap_valid (trap_valid),
  .trap_cause (trap_cause)
);

// File: tb/fpmem_xfer_unit_bench.sv
module fpmem_xfer_unit_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ins_valid = 1'b0;
  logic        ins_ready;
  logic [31:0] ins_word = '0;
  logic [31:0] rs1_val = '0;
  logic [31:0] rs2_val = '0;
  logic        mem_req;
  logic        mem_rdy = 1'b0;
  logic        mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = '0;
  logic        trap_valid;
  logic [1:0]  trap_cause;

  always #2.5 clk = ~clk;

  fpmem_xfer_unit u_fpmem_xfer_unit (
    .clk(clk), .rst_n(rst_n), .ins_valid(ins_valid), .ins_ready(ins_ready),
    .ins_word(ins_word), .rs1_val(rs1_val), .rs2_val(rs2_val),
    .mem_req(mem_req), .mem_rdy(mem_rdy), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .trap_valid(trap_valid), .trap_cause(trap_cause)
  );

  int check_cnt = 0;
  int fail_cnt  = 0;

  logic [31:0] bmem [128];
  logic [31:0] mreg [32];
  logic [31:0] log_addr [4];
  logic        log_we   [4];
  logic [31:0] log_wd   [4];
  int          log_n = 0;
  int          stall_cfg = 0;
  int          wait_cnt = 0;

  int          t_cnt;
  logic [1:0]  t_cause;
  logic        t_first;
  logic        t_busy;

  function automatic logic [31:0] pat(int i);
    logic [31:0] v;
    v = 32'(i) * 32'h0002_0409;
    return 32'hC3A5_0000 ^ v;
  endfunction

  function automatic logic [31:0] mk(logic [1:0] top, logic [5:0] op3, logic [4:0] rd,
                                     logic isel, logic [12:0] imm);
    return {top, rd, op3, 5'd0, isel, isel ? imm : 13'd0};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    check_cnt++;
    if (!ok) begin
      fail_cnt++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // memory model: grants after stall_cfg wait cycles
  always @(negedge clk) begin
    if (mem_req) begin
      if (wait_cnt >= stall_cfg) begin
        mem_rdy  = 1'b1;
        mem_rdata = bmem[mem_addr[8:2]];
        if (log_n < 4) begin
          log_addr[log_n] = mem_addr;
          log_we[log_n]   = mem_we;
          log_wd[log_n]   = mem_wdata;
        end
        log_n++;
        if (mem_we) bmem[mem_addr[8:2]] = mem_wdata;
        wait_cnt = 0;
      end else begin
        mem_rdy = 1'b0;
        wait_cnt++;
      end
    end else begin
      mem_rdy  = 1'b0;
      wait_cnt = 0;
    end
  end

  task automatic run_op(logic [31:0] w, logic [31:0] a, logic [31:0] b);
    int n;
    log_n = 0;
    @(negedge clk);
    ins_word = w; rs1_val = a; rs2_val = b; ins_valid = 1'b1;
    @(negedge clk);
    ins_valid = 1'b0;
    t_first = trap_valid;
    t_busy  = !ins_ready;
    t_cnt = 0; t_cause = 2'b00; n = 0;
    while (!ins_ready && n < 1000) begin
      if (trap_valid) begin t_cnt++; t_cause = trap_cause; end
      @(negedge clk);
      n++;
    end
  endtask

  task automatic verify_regs(string req);
    for (int r = 0; r < 32; r++) begin
      stall_cfg = (r + 1) % 3;
      run_op(mk(2'b11, 6'h24, 5'(r), 1'b0, 13'd0), 32'h100, 32'(4 * r));
      chk(log_n == 1 && log_wd[0] == mreg[r], req, log_wd[0], mreg[r]);
    end
  endtask

  initial begin
    for (int i = 0; i < 128; i++) bmem[i] = pat(i);
    repeat (4) @(negedge clk);
    chk(ins_ready == 1'b1, "R12 reset ready", 32'(ins_ready), 32'd1);
    chk(mem_req == 1'b0 && trap_valid == 1'b0, "R12 reset idle",
        {30'd0, mem_req, trap_valid}, 32'd0);
    rst_n = 1'b1;

    // R3 / R2: word loads, immediate mode, negative and positive offsets
    for (int r = 0; r < 32; r++) begin
      stall_cfg = r % 4;
      run_op(mk(2'b11, 6'h20, 5'(r), 1'b1, 13'(4 * r - 32)), 32'h20, 32'hDEAD_0000);
      mreg[r] = pat(r);
      chk(log_n == 1, "R3 one request", 32'(log_n), 32'd1);
      chk(log_addr[0] == 32'(4 * r) && log_we[0] == 1'b0, "R2 ea imm", log_addr[0], 32'(4 * r));
      chk(t_busy, "R12 busy after accept", 32'(t_busy), 32'd1);
    end

    // R4 / R1: word stores, register-register mode
    for (int r = 0; r < 32; r++) begin
      stall_cfg = 3 - (r % 4);
      run_op(mk(2'b11, 6'h24, 5'(r), 1'b0, 13'd0), 32'h100, 32'(4 * r));
      chk(log_n == 1 && log_we[0] == 1'b1, "R4 one write", 32'(log_n), 32'd1);
      chk(log_addr[0] == 32'h100 + 32'(4 * r), "R1 ea reg", log_addr[0], 32'h100 + 32'(4 * r));
      chk(log_wd[0] == mreg[r], "R4 store data", log_wd[0], mreg[r]);
    end

    // R4: word store at a non-word-aligned address is issued unchanged
    stall_cfg = 1;
    run_op(mk(2'b11, 6'h24, 5'd7, 1'b0, 13'd0), 32'h101, 32'd2);
    chk(log_n == 1 && t_cnt == 0, "R4 no trap", 32'(t_cnt), 32'd0);
    chk(log_addr[0] == 32'h103, "R4 odd address", log_addr[0], 32'h103);

    // R1: address wraps modulo 2^32
    run_op(mk(2'b11, 6'h24, 5'd3, 1'b0, 13'd0), 32'hFFFF_FFF0, 32'h0000_0114);
    chk(log_addr[0] == 32'h0000_0104, "R1 wrap", log_addr[0], 32'h104);

    // R5: doubleword loads
    for (int k = 0; k < 16; k++) begin
      logic [31:0] ea;
      stall_cfg = k % 4;
      ea = 32'(8 * (k + 16));
      if (k % 2 == 0) run_op(mk(2'b11, 6'h23, 5'(2 * k), 1'b0, 13'd0), 32'h80, 32'(8 * k));
      else            run_op(mk(2'b11, 6'h23, 5'(2 * k), 1'b1, 13'(8 * k)), 32'h80, 32'h0);
      mreg[2 * k]     = bmem[ea[8:2]];
      mreg[2 * k + 1] = bmem[ea[8:2] + 7'd1];
      chk(log_n == 2, "R5 two beats", 32'(log_n), 32'd2);
      chk(log_addr[0] == ea && log_addr[1] == ea + 32'd4, "R5 beat addresses", log_addr[1], ea + 32'd4);
      chk(!log_we[0] && !log_we[1], "R5 reads", {30'd0, log_we[0], log_we[1]}, 32'd0);
    end

    // R6: doubleword stores
    for (int k = 0; k < 16; k++) begin
      logic [31:0] ea;
      stall_cfg = (k + 2) % 4;
      ea = 32'h180 + 32'(8 * k);
      run_op(mk(2'b11, 6'h27, 5'(2 * k), 1'b0, 13'd0), 32'h180, 32'(8 * k));
      chk(log_n == 2 && log_we[0] && log_we[1], "R6 two writes", 32'(log_n), 32'd2);
      chk(log_addr[0] == ea && log_addr[1] == ea + 32'd4, "R6 order", log_addr[0], ea);
      chk(log_wd[0] == mreg[2 * k], "R6 first word", log_wd[0], mreg[2 * k]);
      chk(log_wd[1] == mreg[2 * k + 1], "R6 second word", log_wd[1], mreg[2 * k + 1]);
    end

    // R7: misaligned doublewords (odd and even rd, both directions)
    for (int lo = 1; lo < 8; lo++) begin
      for (int st = 0; st < 2; st++) begin
        run_op(mk(2'b11, st ? 6'h27 : 6'h23, 5'(lo + 2), 1'b1, 13'(lo)), 32'h40, 32'h0);
        chk(log_n == 0, "R7 no request", 32'(log_n), 32'd0);
        chk(t_first && t_cnt == 1, "R10 trap pulse", 32'(t_cnt), 32'd1);
        chk(t_cause == 2'b01, "R7 cause", {30'd0, t_cause}, 32'd1);
      end
    end

    // R8: odd register with aligned address
    for (int r = 1; r < 32; r += 2) begin
      for (int st = 0; st < 2; st++) begin
        run_op(mk(2'b11, st ? 6'h27 : 6'h23, 5'(r), 1'b0, 13'd0), 32'h10, 32'h0);
        chk(log_n == 0 && t_cnt == 1, "R8 no request", 32'(log_n), 32'd0);
        chk(t_cause == 2'b10, "R8 cause", {30'd0, t_cause}, 32'd2);
      end
    end

    // R9: unknown operation codes and wrong major field
    for (int op = 0; op < 64; op++) begin
      if (op == 'h20 || op == 'h23 || op == 'h24 || op == 'h27) continue;
      run_op(mk(2'b11, 6'(op), 5'd4, 1'b0, 13'd0), 32'h8, 32'h0);
      chk(log_n == 0 && t_first && t_cnt == 1, "R9 no request", 32'(log_n), 32'd0);
      chk(t_cause == 2'b10, "R9 cause", {30'd0, t_cause}, 32'd2);
    end
    for (int top = 0; top < 3; top++) begin
      run_op(mk(2'(top), 6'h20, 5'd6, 1'b0, 13'd0), 32'h8, 32'h0);
      chk(log_n == 0 && t_cause == 2'b10, "R9 major field", {30'd0, t_cause}, 32'd2);
    end

    // R7 R8 R9: no register changed by any trapped instruction
    verify_regs("R7 R8 R9 regs unchanged");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", check_cnt, fail_cnt);
    $finish;
  end

endmodule